// File: doc/BRIEF.md
# Nibble-Serial CRC-16 Map Header Generator

This block folds a stream of 32-bit quadlets into a 16-bit check value, four bits per clock, and then forms the header quadlet that leads a bus topology map or a speed map. Software-independent logic that builds such a map streams every quadlet after the header slot into the block. After the final quadlet the block pulses `done`, and it presents both the check value and the complete header word. The header word is the map length in its upper half and the check value in its lower half.

A map begins with a one-cycle `start` pulse that also selects the map kind. For a topology map the length field is the number of quadlets actually streamed. A producer that streams the self-ID records plus the two leading fixed quadlets therefore obtains a length of self-ID count + 2. For a speed map the length field is the fixed constant 0x3F1, regardless of how many quadlets were streamed.

The input is a valid/ready stream. A quadlet transfers on a rising clock edge where `in_valid` and `in_ready` are both high. A producer may hold `in_valid` high with stable data for as long as `in_ready` stays low. Holding `in_valid` low simply stalls the map. The block raises `in_ready` only when it can take a quadlet. That is never while a previous quadlet still has nibbles left to fold, never outside a map, and never in a cycle where `start` is high.

Top module: `map_hdr_crc16`

## Requirements
- R1: Out of reset, `in_ready` and `done` are low, and `crc_out` and `header_out` are zero.
- R2: A `start` pulse outside nibble processing clears the check value and the quadlet count and latches `map_kind` (0 = topology, 1 = speed). In the next cycle `in_ready` is high.
- R3: The check value starts at zero for each map. Each quadlet is folded as eight nibbles, from bits [31:28] down to bits [3:0]. For each nibble n: s = crc[15:12] ^ n, then crc = (crc << 4) ^ (s << 12) ^ (s << 5) ^ s, kept to 16 bits. For example, a lone quadlet 0x0000000F gives 0xF1EF.
- R4: After a quadlet is accepted, `in_ready` stays low for seven cycles. With `in_valid` held high, consecutive quadlets are accepted exactly 8 cycles apart.
- R5: A quadlet transfers only on an edge where `in_valid` and `in_ready` are both high. Idle gaps in `in_valid` do not change the final check value.
- R6: `done` is a one-cycle pulse. It rises on the eighth clock edge after the edge that accepted the quadlet marked `in_last`, and `crc_out` holds the final value from that cycle on.
- R7: For a topology map, `header_out[31:16]` is the number of quadlets accepted since `start`, and `header_out[15:0]` is the check value.
- R8: For a speed map, `header_out[31:16]` is 0x3F1 and `header_out[15:0]` is the check value.
- R9: After `done`, `crc_out` and `header_out` hold until the next `start`. `in_ready` stays low, and `in_valid` in that period has no effect.
- R10: A `start` pulse that arrives while a quadlet is being folded is ignored, and the map in progress continues unchanged.
- R11: In a cycle where `start` is high, `in_ready` is low, so no quadlet transfers on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new map (one-cycle pulse) |
| map_kind | input | 1 | Map kind sampled with start: 0 topology, 1 speed |
| in_valid | input | 1 | Quadlet on in_data is valid |
| in_ready | output | 1 | Block can accept a quadlet this cycle |
| in_data | input | 32 | Quadlet to fold into the check value |
| in_last | input | 1 | This quadlet is the final one of the map |
| crc_out | output | 16 | Running / final check value |
| header_out | output | 32 | Map header: length in [31:16], check value in [15:0] |
| done | output | 1 | One-cycle pulse when the header is complete |

## Verification
A wrong nibble order or a wrong update term corrupts `crc_out` on the cycle after the first quadlet completes, and `header_out[15:0]` with it. A broken step counter shows up within one quadlet: `in_ready` returns early or late against the 8-cycle cadence, and `done` moves off its fixed distance from the last accepted quadlet. A lost start-clear, or a count that steps wrongly, first appears in the length field once `done` rises. The bench therefore compares readiness and `done` on every clock, and compares the check value and header in every cycle outside nibble processing.

// File: rtl/maphdr_pkg.sv
package maphdr_pkg;

  localparam int CRC_W = 16;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_TAKE  = 2'd1,
    PH_SHIFT = 2'd2
  } phase_t;

  // one nibble of the shift-xor check update
  function automatic logic [CRC_W-1:0] nib_advance(input logic [CRC_W-1:0] c,
                                                   input logic [NIB_W-1:0] n);
    logic [NIB_W-1:0] s;
    s = c[CRC_W-1 -: NIB_W] ^ n;
    return {c[CRC_W-NIB_W-1:0], {NIB_W{1'b0}}}
         ^ {s, 12'h000}
         ^ {7'd0, s, 5'd0}
         ^ {12'h000, s};
  endfunction

endpackage

// File: rtl/crc_lane_chain.sv
module crc_lane_chain
  import maphdr_pkg::*;
#(
  parameter  int LANES  = 1,
  localparam int STEP_W = NIB_W * LANES
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [STEP_W-1:0] chunk,
  output logic [CRC_W-1:0]  crc_out
);

  logic [CRC_W-1:0] stage [LANES+1];

  assign stage[0] = crc_in;

  // most significant nibble of the chunk is folded first
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign stage[l+1] = nib_advance(stage[l], chunk[STEP_W-1-NIB_W*l -: NIB_W]);
  end

  assign crc_out = stage[LANES];

endmodule

// File: rtl/quad_nibbler.sv
module quad_nibbler #(
  parameter int DATA_W = 32,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [DATA_W-1:0] data_in,
  output logic [STEP_W-1:0] chunk
);

  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sh_q <= '0;
    else if (load) sh_q <= data_in;
    else if (adv)  sh_q <= sh_q << STEP_W;
  end

  assign chunk = sh_q[DATA_W-1 -: STEP_W];

  AST_LOAD_TOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> chunk == $past(data_in[DATA_W-1 -: STEP_W])); // R3

endmodule

// File: rtl/map_seq_ctrl.sv
module map_seq_ctrl
  import maphdr_pkg::*;
#(
  parameter  int STEPS = 8,
  localparam int IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_valid,
  input  logic in_last,
  output logic in_ready,
  output logic take,
  output logic clear,
  output logic step_en,
  output logic commit,
  output logic fin
);

  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(STEPS - 1);

  phase_t           ph_q;
  logic [IDX_W-1:0] idx_q;
  logic             last_q;
  logic             final_step;

  assign final_step = (ph_q == PH_SHIFT) && (idx_q == IDX_END);
  assign clear      = start && (ph_q != PH_SHIFT);
  assign in_ready   = ((ph_q == PH_TAKE) || (final_step && !last_q)) && !start;
  assign take       = in_ready && in_valid;
  assign step_en    = (ph_q == PH_SHIFT);
  assign commit     = final_step;
  assign fin        = final_step && last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      idx_q  <= '0;
      last_q <= 1'b0;
    end else if (clear) begin
      ph_q  <= PH_TAKE;
      idx_q <= '0;
    end else begin
      unique case (ph_q)
        PH_TAKE: begin
          if (take) begin
            ph_q   <= PH_SHIFT;
            idx_q  <= '0;
            last_q <= in_last;
          end
        end
        PH_SHIFT: begin
          if (final_step) begin
            idx_q <= '0;
            if (last_q) begin
              ph_q <= PH_IDLE;
            end else if (take) begin
              ph_q   <= PH_SHIFT;
              last_q <= in_last;
            end else begin
              ph_q <= PH_TAKE;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  AST_NO_TAKE_MID_QUADLET: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SHIFT && idx_q != IDX_END) |-> !in_ready); // R4

  AST_IDLE_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE) |-> !in_ready); // R9

  AST_START_BLOCKS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !take); // R11

  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ph_q == PH_SHIFT && !final_step) |=> ph_q == PH_SHIFT); // R10

endmodule

// File: rtl/map_hdr_regs.sv
module map_hdr_regs
  import maphdr_pkg::*;
#(
  parameter int               CNT_W     = 16,
  parameter logic [CNT_W-1:0] SPEED_LEN = 'h3F1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   kind_in,
  input  logic                   step_en,
  input  logic                   commit,
  input  logic                   fin,
  input  logic [CRC_W-1:0]       crc_nxt,
  output logic [CRC_W-1:0]       crc_q,
  output logic [CNT_W+CRC_W-1:0] header,
  output logic                   done
);

  logic [CNT_W-1:0] cnt_q;
  logic             kind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= '0;
      cnt_q  <= '0;
      kind_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= fin;
      if (clear) begin
        crc_q  <= '0;
        cnt_q  <= '0;
        kind_q <= kind_in;
      end else begin
        if (step_en) crc_q <= crc_nxt;
        if (commit)  cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign header = {(kind_q ? SPEED_LEN : cnt_q), crc_q};

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (crc_q == '0) && (cnt_q == '0)); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_COUNT_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)); // R7

endmodule

// File: rtl/map_hdr_crc16.sv
module map_hdr_crc16
  import maphdr_pkg::*;
#(
  parameter int               DATA_W    = 32,
  parameter int               LANES     = 1,
  parameter int               CNT_W     = 16,
  parameter logic [CNT_W-1:0] SPEED_LEN = 'h3F1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   map_kind,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [DATA_W-1:0]      in_data,
  input  logic                   in_last,
  output logic [CRC_W-1:0]       crc_out,
  output logic [CNT_W+CRC_W-1:0] header_out,
  output logic                   done
);

  localparam int STEP_W = NIB_W * LANES;
  localparam int STEPS  = DATA_W / STEP_W;

  logic              take, clear, step_en, commit, fin;
  logic [STEP_W-1:0] chunk;
  logic [CRC_W-1:0]  crc_q, crc_nxt;

  map_seq_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_ready (in_ready),
    .take     (take),
    .clear    (clear),
    .step_en  (step_en),
    .commit   (commit),
    .fin      (fin)
  );

  quad_nibbler #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_nib (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (take),
    .adv     (step_en),
    .data_in (in_data),
    .chunk   (chunk)
  );

  crc_lane_chain #(.LANES(LANES)) u_lanes (
    .crc_in  (crc_q),
    .chunk   (chunk),
    .crc_out (crc_nxt)
  );

  map_hdr_regs #(.CNT_W(CNT_W), .SPEED_LEN(SPEED_LEN)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .kind_in (map_kind),
    .step_en (step_en),
    .commit  (commit),
    .fin     (fin),
    .crc_nxt (crc_nxt),
    .crc_q   (crc_q),
    .header  (header_out),
    .done    (done)
  );

  assign crc_out = crc_q;

  AST_HEADER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(header_out)); // R9

  AST_DONE_AFTER_QUADLET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(commit)); // R6

endmodule

// File: tb/test_map_hdr_crc16.sv
`timescale 1ns/1ps
module test_map_hdr_crc16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        map_kind = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_last = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic [15:0] crc_out;
  logic [31:0] header_out;
  logic        done;

  always #2 clk = ~clk;

  map_hdr_crc16 i_map_hdr_crc16 (
    .clk(clk), .rst_n(rst_n), .start(start), .map_kind(map_kind),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .crc_out(crc_out), .header_out(header_out), .done(done)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural check-value reference over one whole quadlet (R3)
  function automatic logic [15:0] quad_crc(input logic [15:0] c0, input logic [31:0] q);
    int c;
    c = c0;
    for (int sh = 28; sh >= 0; sh -= 4) begin
      int s;
      s = ((c >> 12) ^ (q >> sh)) & 15;
      c = ((c << 4) ^ (s << 12) ^ (s << 5) ^ s) & 16'hFFFF;
    end
    return c[15:0];
  endfunction

  // reference model: 0 idle, 1 waiting for a quadlet, 2 folding
  int          m_st = 0;
  int          m_tmr = 0;
  int          m_cnt = 0;
  logic [15:0] m_crc = '0;
  logic [15:0] m_pend = '0;
  bit          m_kind = 0;
  bit          m_last = 0;
  bit          m_done = 0;

  function automatic bit exp_ready();
    return ((m_st == 1) || (m_st == 2 && m_tmr == 1 && !m_last)) && !start;
  endfunction

  always @(posedge clk) begin : ref_model
    bit hs;
    cyc++;
    hs = exp_ready() && in_valid;
    if (!rst_n) begin
      m_st = 0; m_tmr = 0; m_cnt = 0; m_crc = '0; m_kind = 0; m_last = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (start && m_st != 2) begin
        m_crc = '0; m_cnt = 0; m_kind = map_kind; m_st = 1;
      end else if (m_st == 1) begin
        if (hs) begin
          m_pend = quad_crc(m_crc, in_data); m_last = in_last; m_tmr = 8; m_st = 2;
        end
      end else if (m_st == 2) begin
        m_tmr--;
        if (m_tmr == 0) begin
          m_crc = m_pend;
          m_cnt = (m_cnt + 1) & 16'hFFFF;
          if (m_last) begin
            m_done = 1; m_st = 0;
          end else if (hs) begin
            m_pend = quad_crc(m_crc, in_data); m_last = in_last; m_tmr = 8; m_st = 2;
          end else begin
            m_st = 1;
          end
        end
      end
    end
  end

  // per-clock comparison against the model, away from the edge
  always @(posedge clk) begin : compare
    logic [31:0] hexp;
    #1;
    chk(in_ready == exp_ready(), "R4", "in_ready", {31'd0, in_ready}, {31'd0, exp_ready()});
    chk(done == m_done, "R6", "done", {31'd0, done}, {31'd0, m_done});
    if (m_st != 2) begin
      hexp = {(m_kind ? 16'h03F1 : m_cnt[15:0]), m_crc};
      chk(crc_out == m_crc, "R3", "crc_out", {16'd0, crc_out}, {16'd0, m_crc});
      chk(header_out == hexp, m_kind ? "R8" : "R7", "header_out", header_out, hexp);
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // all tasks are entered and left at a falling edge
  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start(input bit kind);
    start = 1'b1; map_kind = kind;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send(input logic [31:0] d, input bit lst, output int acc);
    in_valid = 1'b1; in_data = d; in_last = lst;
    forever begin
      #0.5;
      if (in_ready) begin
        acc = cyc;
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic wait_done(output int dc);
    in_valid = 1'b0;
    dc = -1;
    for (int k = 0; k < 40; k++) begin
      #0.5;
      if (done) begin
        dc = cyc;
        break;
      end
      @(negedge clk);
    end
  endtask

  logic [31:0] qa [5];

  initial begin
    int a0, a1, a2, dc;
    logic [15:0] e, e_top;
    qa[0] = 32'h8000_1234; qa[1] = 32'hDEAD_BEEF; qa[2] = 32'h0F0F_00A5;
    qa[3] = 32'h1357_9BDF; qa[4] = 32'hFFFF_0001;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #0.5;
    chk(in_ready == 1'b0, "R1", "in_ready after reset", {31'd0, in_ready}, 32'd0);
    chk(done == 1'b0, "R1", "done after reset", {31'd0, done}, 32'd0);
    chk(crc_out == 16'd0, "R1", "crc after reset", {16'd0, crc_out}, 32'd0);
    chk(header_out == 32'd0, "R1", "header after reset", header_out, 32'd0);
    @(negedge clk);

    // topology map, three quadlets back to back
    pulse_start(1'b0);
    #0.5;
    chk(in_ready == 1'b1, "R2", "ready after start", {31'd0, in_ready}, 32'd1);
    chk(header_out == 32'd0, "R2", "header cleared", header_out, 32'd0);
    @(negedge clk);
    send(qa[0], 1'b0, a0);
    send(qa[1], 1'b0, a1);
    send(qa[2], 1'b1, a2);
    chk(a1 - a0 == 8, "R4", "quadlet spacing 1", a1 - a0, 8);
    chk(a2 - a1 == 8, "R4", "quadlet spacing 2", a2 - a1, 8);
    wait_done(dc);
    // accept edge ends cycle a2; eight edges later the counter reads a2+9
    chk(dc - a2 == 9, "R6", "done latency", dc - a2, 9);
    e_top = quad_crc(quad_crc(quad_crc(16'd0, qa[0]), qa[1]), qa[2]);
    chk(crc_out == e_top, "R3", "topology check value", {16'd0, crc_out}, {16'd0, e_top});
    chk(header_out == {16'd3, e_top}, "R7", "topology header", header_out, {16'd3, e_top});
    @(negedge clk); #0.5;
    chk(done == 1'b0, "R6", "done one cycle", {31'd0, done}, 32'd0);
    @(negedge clk);

    // traffic after done must not disturb anything
    in_valid = 1'b1; in_data = 32'h5555_AAAA; in_last = 1'b0;
    repeat (10) @(negedge clk);
    #0.5;
    chk(in_ready == 1'b0, "R9", "ready after done", {31'd0, in_ready}, 32'd0);
    chk(header_out == {16'd3, e_top}, "R9", "header holds", header_out, {16'd3, e_top});
    @(negedge clk);
    idle(1);

    // speed map, same data with gaps
    pulse_start(1'b1);
    for (int i = 0; i < 3; i++) begin
      idle(i % 3 + 1);
      send(qa[i], i == 2, a0);
    end
    wait_done(dc);
    chk(crc_out == e_top, "R5", "gapped stream check value", {16'd0, crc_out}, {16'd0, e_top});
    chk(header_out == {16'h03F1, e_top}, "R8", "speed header", header_out, {16'h03F1, e_top});
    @(negedge clk);

    // start while folding is ignored
    pulse_start(1'b0);
    send(qa[3], 1'b0, a0);
    idle(2);
    pulse_start(1'b0);
    send(qa[4], 1'b1, a1);
    wait_done(dc);
    e = quad_crc(quad_crc(16'd0, qa[3]), qa[4]);
    chk(header_out == {16'd2, e}, "R10", "start during folding", header_out, {16'd2, e});
    @(negedge clk);

    // start and valid in the same cycle: no transfer
    pulse_start(1'b0);
    start = 1'b1; in_valid = 1'b1; in_data = qa[0]; in_last = 1'b1;
    #0.5;
    chk(in_ready == 1'b0, "R11", "ready with start", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    start = 1'b0;
    send(qa[0], 1'b1, a0);
    wait_done(dc);
    e = quad_crc(16'd0, qa[0]);
    chk(header_out == {16'd1, e}, "R11", "single quadlet header", header_out, {16'd1, e});
    @(negedge clk);

    // hand-computed vectors
    pulse_start(1'b0);
    send(32'h0000_000F, 1'b1, a0);
    wait_done(dc);
    chk(crc_out == 16'hF1EF, "R3", "lone 0x0000000F", {16'd0, crc_out}, 32'h0000_F1EF);
    @(negedge clk);
    pulse_start(1'b0);
    send(32'h0000_0000, 1'b1, a0);
    wait_done(dc);
    chk(crc_out == 16'h0000, "R3", "lone zero quadlet", {16'd0, crc_out}, 32'd0);
    @(negedge clk);

    idle(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule